// File: doc/BRIEF.md
# Indexed Super-IO Configuration Port

This block is a byte-wide table of 256 configuration entries. Software reaches it through two adjacent I/O addresses. Writing the lower address chooses an entry. Writing the upper address stores a byte into the chosen entry. Reading either address returns the chosen entry. Most entries are read-only. Two entries take exactly one legal value and drop every other write. The remaining entries store any byte.

Both addresses respond only while an enable bit is set. That bit lives in a byte of the surrounding bridge's configuration space, and the block watches writes to that byte. After reset the pair is disabled. While disabled, reads float high and writes are dropped. The devices that the entries would configure are not part of this block.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, entry 0xE0 reads 0x3C, 0xE2 reads 0x03, 0xE3 reads 0xFC, 0xE6 reads 0xDE, 0xE7 reads 0xFE and 0xE8 reads 0xBE. Every other entry and the selected index read 0x00. `io_rdata` resets to 0xFF and `io_claim` resets to 0.
- R2: An enabled write to address 0x3F0 loads `io_wdata` as the selected index. A read of 0x3F0 or of 0x3F1 returns the entry at that index.
- R3: Data-port (0x3F1) writes leave the selected entry unchanged when the index is 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: Entry 0xE7 stores a data-port write only when the byte is 0xFE. Any other byte is discarded.
- R5: Entry 0xE8 stores a data-port write only when the byte is 0xBE. Any other byte is discarded.
- R6: Entries 0xE0–0xE3, 0xE6, 0xEE, 0xEF, 0xF0–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC store any byte written through the data port.
- R7: Reads have no side effect. Repeated reads return the same byte, and the index does not change.
- R8: A `cfg_wr` to configuration address 0x85 sets the enable to bit 1 of `cfg_wdata`. The new value is in force from the next cycle. Writes to other configuration addresses leave the enable unchanged.
- R9: While the enable is clear, a read of 0x3F0 or 0x3F1 returns 0xFF with `io_claim` low. Writes to those addresses change neither the index nor any entry.
- R10: `io_rdata` and `io_claim` are registered, one cycle after the access. `io_claim` is high only after an enabled read or write to 0x3F0 or 0x3F1. A read of any other address leaves `io_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Bridge configuration byte write strobe |
| cfg_addr | input | 8 | Bridge configuration byte address |
| cfg_wdata | input | 8 | Bridge configuration byte write data |
| io_addr | input | 16 | I/O access address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | Registered read byte |
| io_claim | output | 1 | Registered flag: the last access was decoded by this block |

## Verification
Three results are due one clock edge after their stimulus.
- An index or entry write is visible to a read that starts on the next cycle.
- An enable change made through the configuration byte applies to the next access.
- Read data and the claim flag appear at the edge that samples the read strobe.

The bench drives every strobe on a falling edge and removes it on the next falling edge. It samples `io_rdata` and `io_claim` at that second falling edge, which falls exactly one rising edge after the access. The sweeps cover all 256 indices, so every entry is checked for its reset value and for its write-protection class.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int IDX_W       = 8;
  localparam int ENTRY_W     = 8;
  localparam int NUM_ENTRIES = 1 << IDX_W;

  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [ENTRY_W-1:0] entry_t;

  // Entries that hold storage and may change after reset
  function automatic logic entry_writable(idx_t i);
    case (i)
      8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hE7, 8'hE8, 8'hEE,
      8'hEF, 8'hF0, 8'hF1, 8'hF2, 8'hF4, 8'hF6, 8'hF8, 8'hFC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic entry_t entry_reset(idx_t i);
    case (i)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  // Entries that accept exactly one value
  function automatic logic entry_locked(idx_t i);
    return (i == 8'hE7) || (i == 8'hE8);
  endfunction

  function automatic entry_t entry_lock_value(idx_t i);
    case (i)
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03F1,
  parameter int CFG_AW      = 8,
  parameter logic [CFG_AW-1:0] EN_CFG_ADDR = 8'h85,
  parameter int EN_CFG_BIT  = 1,
  parameter int CFG_DW      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              port_en,
  output logic              hit_idx,
  output logic              hit_data
);
  always_ff @(posedge clk) begin
    if (rst)
      port_en <= 1'b0;
    else if (cfg_wr && cfg_addr == EN_CFG_ADDR)
      port_en <= cfg_wdata[EN_CFG_BIT];
  end

  assign hit_idx  = (io_addr == INDEX_PORT);
  assign hit_data = (io_addr == DATA_PORT);
endmodule

// File: rtl/sio_index_reg.sv
module sio_index_reg
  import sio_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  idx_t din,
  output idx_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/sio_write_guard.sv
module sio_write_guard
  import sio_cfg_pkg::*;
(
  input  idx_t   idx,
  input  entry_t wdata,
  output logic   accept
);
  logic value_ok;

  assign value_ok = !entry_locked(idx) || (wdata == entry_lock_value(idx));
  assign accept   = entry_writable(idx) && value_ok;
endmodule

// File: rtl/sio_entry_file.sv
module sio_entry_file
  import sio_cfg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   we,
  input  idx_t   wr_idx,
  input  entry_t wr_data,
  input  idx_t   rd_idx,
  output entry_t rd_data
);
  logic [NUM_ENTRIES*ENTRY_W-1:0] flat;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    localparam idx_t GI = idx_t'(g);
    if (entry_writable(GI)) begin : g_rw
      entry_t q;
      always_ff @(posedge clk) begin
        if (rst)                     q <= entry_reset(GI);
        else if (we && wr_idx == GI) q <= wr_data;
      end
      assign flat[g*ENTRY_W +: ENTRY_W] = q;
    end else begin : g_ro
      assign flat[g*ENTRY_W +: ENTRY_W] = entry_reset(GI);
    end
  end

  assign rd_data = flat[rd_idx*ENTRY_W +: ENTRY_W];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03F1,
  parameter int CFG_AW      = 8,
  parameter logic [CFG_AW-1:0] EN_CFG_ADDR = 8'h85,
  parameter int EN_CFG_BIT  = 1,
  parameter int CFG_DW      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [ENTRY_W-1:0]  io_wdata,
  output logic [ENTRY_W-1:0]  io_rdata,
  output logic                io_claim
);
  localparam entry_t FLOAT_BYTE = '1;

  logic   port_en, hit_idx, hit_data, hit_any;
  logic   idx_load, data_wr, accept;
  idx_t   sel_idx;
  entry_t cur_entry;

  sio_port_decode #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
    .CFG_AW(CFG_AW), .EN_CFG_ADDR(EN_CFG_ADDR), .EN_CFG_BIT(EN_CFG_BIT),
    .CFG_DW(CFG_DW)
  ) u_dec (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .io_addr(io_addr), .port_en(port_en),
    .hit_idx(hit_idx), .hit_data(hit_data)
  );

  assign hit_any  = hit_idx || hit_data;
  assign idx_load = port_en && io_wr && hit_idx;
  assign data_wr  = port_en && io_wr && hit_data;

  sio_index_reg u_idx (
    .clk(clk), .rst(rst), .load(idx_load), .din(io_wdata), .q(sel_idx)
  );

  sio_write_guard u_guard (
    .idx(sel_idx), .wdata(io_wdata), .accept(accept)
  );

  sio_entry_file u_file (
    .clk(clk), .rst(rst), .we(data_wr && accept), .wr_idx(sel_idx),
    .wr_data(io_wdata), .rd_idx(sel_idx), .rd_data(cur_entry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= FLOAT_BYTE;
      io_claim <= 1'b0;
    end else begin
      io_claim <= port_en && (io_rd || io_wr) && hit_any;
      if (io_rd && hit_any)
        io_rdata <= port_en ? cur_entry : FLOAT_BYTE;
    end
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03F1,
  parameter int CFG_AW      = 8,
  parameter logic [CFG_AW-1:0] EN_CFG_ADDR = 8'h85,
  parameter int EN_CFG_BIT  = 1,
  parameter int CFG_DW      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_wdata,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_claim,
  input logic              port_en,
  input logic [7:0]        sel_idx,
  input logic [7:0]        cur_entry
);
  localparam logic [CFG_DW-1:0] EN_MASK = CFG_DW'(1) << EN_CFG_BIT;
  logic at_port, dwr;
  assign at_port = (io_addr == INDEX_PORT) || (io_addr == DATA_PORT);
  assign dwr     = port_en && io_wr && (io_addr == DATA_PORT);

  assert_idx_latch_R2: assert property (@(posedge clk) disable iff (rst)
    port_en && io_wr && io_addr == INDEX_PORT |=> sel_idx == $past(io_wdata));
  assert_protected_R3: assert property (@(posedge clk) disable iff (rst)
    dwr && sel_idx < 8'hE0 |=> $stable(cur_entry));
  assert_lock_e7_R4: assert property (@(posedge clk) disable iff (rst)
    dwr && sel_idx == 8'hE7 && io_wdata != 8'hFE |=> $stable(cur_entry));
  assert_lock_e8_R5: assert property (@(posedge clk) disable iff (rst)
    dwr && sel_idx == 8'hE8 && io_wdata != 8'hBE |=> $stable(cur_entry));
  assert_free_R6: assert property (@(posedge clk) disable iff (rst)
    dwr && (sel_idx == 8'hF0 || sel_idx == 8'hE1) |=> cur_entry == $past(io_wdata));
  assert_read_value_R7: assert property (@(posedge clk) disable iff (rst)
    port_en && io_rd && !io_wr && at_port |=> io_rdata == $past(cur_entry) && $stable(sel_idx));
  assert_en_clear_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_addr == EN_CFG_ADDR && (cfg_wdata & EN_MASK) == '0 |=> !port_en);
  assert_disabled_read_R9: assert property (@(posedge clk) disable iff (rst)
    !port_en && io_rd && at_port |=> io_rdata == 8'hFF && !io_claim);
  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> $stable(sel_idx) && $stable(cur_entry));
  assert_no_access_R10: assert property (@(posedge clk) disable iff (rst)
    !(io_rd || io_wr) |=> !io_claim);
  assert_other_addr_R10: assert property (@(posedge clk) disable iff (rst)
    io_rd && !at_port |=> $stable(io_rdata) && !io_claim);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
  .CFG_AW(CFG_AW), .EN_CFG_ADDR(EN_CFG_ADDR), .EN_CFG_BIT(EN_CFG_BIT),
  .CFG_DW(CFG_DW)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_claim(io_claim),
  .port_en(port_en), .sel_idx(sel_idx), .cur_entry(cur_entry)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_claim;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [7:0] exp_mem [256];

  always #4 clk = ~clk;

  sio_cfg_port u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_claim(io_claim)
  );

  function automatic bit tb_storable(int i);
    if (i < 'hE0) return 0;
    if (i == 'hE4 || i == 'hE5) return 0;
    if (i >= 'hE9 && i <= 'hED) return 0;
    if (i == 'hF3 || i == 'hF5 || i == 'hF7) return 0;
    if (i >= 'hF9 && i <= 'hFB) return 0;
    if (i >= 'hFD) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] tb_reset_val(int i);
    case (i)
      'hE0: return 8'h3C;
      'hE2: return 8'h03;
      'hE3: return 8'hFC;
      'hE6: return 8'hDE;
      'hE7: return 8'hFE;
      'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(int i, logic [7:0] v);
    if (!tb_storable(i)) return;
    if (i == 'hE7 && v != 8'hFE) return;
    if (i == 'hE8 && v != 8'hBE) return;
    exp_mem[i] = v;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d, output logic c);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata; c = io_claim;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [7:0] d, d2;
    logic c;
    for (int i = 0; i < 256; i++) exp_mem[i] = tb_reset_val(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state of outputs
    check(io_rdata == 8'hFF, "R1 rdata reset", io_rdata, 8'hFF);
    check(io_claim == 1'b0, "R1 claim reset", io_claim, 0);

    // R9 / R8: disabled after reset
    io_read(16'h03F1, d, c);
    check(d == 8'hFF && !c, "R9 disabled read", {c, d}, 8'hFF);
    io_write(16'h03F0, 8'hE0);
    // R8: wrong config address does not enable
    cfg_write(8'h86, 8'h02);
    io_read(16'h03F1, d, c);
    check(d == 8'hFF && !c, "R8 other cfg addr", {c, d}, 8'hFF);
    cfg_write(8'h85, 8'h02);
    io_read(16'h03F1, d, c);
    // R9: index write while disabled was dropped, index still 0
    check(d == 8'h00 && c, "R9 index held", {c, d}, 9'h100);

    // R1 / R2: reset values, full sweep
    for (int i = 0; i < 256; i++) begin
      io_write(16'h03F0, 8'(i));
      io_read(16'h03F1, d, c);
      check(d == tb_reset_val(i) && c, $sformatf("R1 reset entry %0h", i), d, tb_reset_val(i));
    end
    io_write(16'h03F0, 8'hE6);
    io_read(16'h03F0, d, c);
    check(d == 8'hDE, "R2 read via index port", d, 8'hDE);

    // R3 R4 R5 R6: two write passes, each read back afterwards
    for (int p = 0; p < 2; p++) begin
      logic [7:0] key;
      key = (p == 0) ? 8'hA5 : 8'h3C;
      for (int i = 0; i < 256; i++) begin
        io_write(16'h03F0, 8'(i));
        io_write(16'h03F1, 8'(i) ^ key);
        model_write(i, 8'(i) ^ key);
      end
      for (int i = 0; i < 256; i++) begin
        io_write(16'h03F0, 8'(i));
        io_read(16'h03F1, d, c);
        check(d == exp_mem[i], $sformatf("R3 R4 R5 R6 entry %0h", i), d, exp_mem[i]);
      end
    end

    // R4 / R5: exact values and rejected values
    io_write(16'h03F0, 8'hE8);
    io_write(16'h03F1, 8'h11);
    io_read(16'h03F1, d, c);
    check(d == 8'hBE, "R5 reject 11", d, 8'hBE);
    io_write(16'h03F1, 8'hBE);
    io_read(16'h03F1, d, c);
    check(d == 8'hBE, "R5 accept BE", d, 8'hBE);
    io_write(16'h03F0, 8'hE7);
    io_write(16'h03F1, 8'hFF);
    io_read(16'h03F1, d, c);
    check(d == 8'hFE, "R4 reject FF", d, 8'hFE);

    // R7: repeated reads are stable
    io_write(16'h03F0, 8'hF0);
    io_write(16'h03F1, 8'h5A);
    io_read(16'h03F1, d, c);
    io_read(16'h03F0, d2, c);
    check(d == 8'h5A && d2 == 8'h5A, "R7 repeat read", d2, 8'h5A);

    // R10: other address neither claimed nor changes rdata
    io_read(16'h03F2, d, c);
    check(d == 8'h5A && !c, "R10 other addr read", {c, d}, 8'h5A);
    io_write(16'h03F2, 8'h00);
    check(io_claim == 1'b0, "R10 other addr write claim", io_claim, 0);
    io_write(16'h03F1, 8'h77);
    check(io_claim == 1'b1, "R10 data write claimed", io_claim, 1);

    // R8: bit 1 clear with other bits set disables
    cfg_write(8'h85, 8'hFD);
    io_read(16'h03F1, d, c);
    check(d == 8'hFF && !c, "R8 disable", {c, d}, 8'hFF);
    // R9: writes while disabled dropped
    io_write(16'h03F1, 8'h12);
    io_write(16'h03F0, 8'h00);
    cfg_write(8'h85, 8'h02);
    io_read(16'h03F1, d, c);
    check(d == 8'h77 && c, "R9 writes dropped", {c, d}, 9'h177);

    summary();
  end
endmodule